// File: doc/BRIEF.md
# Three-Level Sign-Steered Pulse Encoder

This block turns a stream of signed 6-bit words from a noise-shaping modulator into two one-bit drive lines, `drv_p` and `drv_n`, for a switching output stage. Its clock runs at 256 times the audio sample rate. A new word is taken once every 32 clocks, which is 8 times the sample rate. The word's sign selects the line that pulses: a positive word pulses `drv_p`, a negative word pulses `drv_n`, and zero pulses neither. The pulse begins on the first clock of the frame, and its length in clocks equals the word's magnitude. The difference of the two lines therefore takes only the values +1, 0 and -1. The lines never rise or fall together.

A small state machine has four states and sets the line levels:
- `ST_OFF` (powered down).
- `ST_DRIVE_P` (positive pulse running).
- `ST_DRIVE_N` (negative pulse running).
- `ST_QUIET` (pulse finished, or the frame is empty).

It makes these transitions:
- *power-down* moves any state to `ST_OFF`.
- *frame-load* occurs on the last clock of a frame. It moves any state to `ST_DRIVE_P`, `ST_DRIVE_N` or `ST_QUIET`, according to the sign of the incoming word.
- *pulse-end* moves `ST_DRIVE_P` or `ST_DRIVE_N` to `ST_QUIET` once the pulse has run for its full length.
- All other cycles hold the current state.

The magnitude is clamped to 31, so the last clock of every frame is always quiet.

Top module: `pwm3_encoder`

## Requirements
- R1: While `rst` is high and on the clock after it is released, `drv_p` and `drv_n` are low. The frame that starts at reset release carries a zero word, so both lines stay low for its 32 clocks.
- R2: A frame is 32 clocks long. `word_in` is sampled on the 32nd rising edge after reset (or power-down) is released, and then on every 32nd edge after that. The sampled word governs the 32 clocks that follow that edge.
- R3: A positive word k (two's complement, 1..31) drives `drv_p` high for the first k clocks of its frame and low for the rest. `drv_n` stays low for the whole frame.
- R4: A negative word -k (1..31) drives `drv_n` high for the first k clocks of its frame. `drv_p` stays low for the whole frame.
- R5: A zero word keeps both lines low for the whole frame.
- R6: The word -32 (bit pattern 100000) is clamped to a `drv_n` pulse of 31 clocks.
- R7: `drv_p` and `drv_n` are never high together. They never change on the same clock edge. Both are low on the last clock of every frame.
- R8: While `pwr_down` is high, both lines are low in that same cycle. The frame count and the stored word are cleared. After `pwr_down` falls, the block behaves as it does after reset release.
- R9: Changes on `word_in` at any edge other than the sampling edge have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at 256x sample rate |
| rst | input | 1 | Synchronous active-high reset |
| pwr_down | input | 1 | Holds the outputs low and restarts framing |
| word_in | input | 6 | Signed modulator word, two's complement |
| drv_p | output | 1 | Positive-side pulse line |
| drv_n | output | 1 | Negative-side pulse line |

## Verification
The assertions assume that `word_in` is steady around each rising edge. They also assume that `pwr_down` is synchronous to `clk`. They assume nothing about the values the words take: every 6-bit pattern, including -32, must keep the lines exclusive. The stimulus changes every input on the falling edge only. It covers the magnitude extremes, sign reversals across frame boundaries and power-down mid-pulse. It also scrambles `word_in` between sampling edges, so the ignore-behaviour is exercised while each assertion's input assumptions still hold.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_DRIVE_P = 2'd1,
        ST_DRIVE_N = 2'd2,
        ST_QUIET   = 2'd3
    } pwm3_state_e;
endpackage

// File: rtl/pwm3_frame_ctr.sv
module pwm3_frame_ctr #(
    parameter int FRAME_LEN = 32,
    localparam int CNT_W = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_down,
    output logic [CNT_W-1:0] pos,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

    assign wrap = (pos == LAST) && !pwr_down;

    always_ff @(posedge clk) begin
        if (rst || pwr_down) begin
            pos <= '0;
        end else if (pos == LAST) begin
            pos <= '0;
        end else begin
            pos <= pos + 1'b1;
        end
    end

    // R8: after a power-down cycle the frame restarts at position zero
    a_r8_restart: assert property (@(posedge clk) disable iff (rst)
        pwr_down |=> (pos == '0));
endmodule

// File: rtl/pwm3_word_latch.sv
module pwm3_word_latch #(
    parameter int WORD_W    = 6,
    parameter int FRAME_LEN = 32,
    localparam int CNT_W    = $clog2(FRAME_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_down,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    output logic              in_pos,
    output logic              in_neg,
    output logic [CNT_W-1:0]  mag_q
);
    localparam int MAX_MAG = FRAME_LEN - 1;

    logic [WORD_W-1:0] absval;
    logic [CNT_W-1:0]  mag_in;

    assign in_neg = word_in[WORD_W-1];
    assign in_pos = !word_in[WORD_W-1] && (word_in != '0);
    assign absval = in_neg ? (~word_in + 1'b1) : word_in;

    always_comb begin
        if (int'(absval) > MAX_MAG) begin
            mag_in = CNT_W'(MAX_MAG);
        end else begin
            mag_in = CNT_W'(absval);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || pwr_down) begin
            mag_q <= '0;
        end else if (load) begin
            mag_q <= mag_in;
        end
    end

    // R9: the stored magnitude moves only on a sampling edge
    a_r9_hold_between_loads: assert property (@(posedge clk) disable iff (rst)
        (!load && !pwr_down) |=> $stable(mag_q));
endmodule

// File: rtl/pwm3_encoder.sv
module pwm3_encoder
    import pwm3_pkg::*;
#(
    parameter int WORD_W    = 6,
    parameter int FRAME_LEN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_down,
    input  logic [WORD_W-1:0] word_in,
    output logic              drv_p,
    output logic              drv_n
);
    localparam int CNT_W = $clog2(FRAME_LEN);

    logic [CNT_W-1:0] pos;
    logic             wrap;
    logic             in_pos;
    logic             in_neg;
    logic [CNT_W-1:0] mag_q;
    logic             pulse_done;
    pwm3_state_e      state, state_nx;

    pwm3_frame_ctr #(.FRAME_LEN(FRAME_LEN)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .pwr_down (pwr_down),
        .pos      (pos),
        .wrap     (wrap)
    );

    pwm3_word_latch #(.WORD_W(WORD_W), .FRAME_LEN(FRAME_LEN)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .pwr_down (pwr_down),
        .load     (wrap),
        .word_in  (word_in),
        .in_pos   (in_pos),
        .in_neg   (in_neg),
        .mag_q    (mag_q)
    );

    assign pulse_done = ({1'b0, pos} + 1'b1) == {1'b0, mag_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_QUIET;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        if (pwr_down) begin
            state_nx = ST_OFF;
        end else if (wrap) begin
            if (in_pos)      state_nx = ST_DRIVE_P;
            else if (in_neg) state_nx = ST_DRIVE_N;
            else             state_nx = ST_QUIET;
        end else begin
            unique case (state)
                ST_DRIVE_P: if (pulse_done) state_nx = ST_QUIET;
                ST_DRIVE_N: if (pulse_done) state_nx = ST_QUIET;
                ST_QUIET:   state_nx = ST_QUIET;
                ST_OFF:     state_nx = ST_OFF;
            endcase
        end
    end

    always_comb begin
        drv_p = 1'b0;
        drv_n = 1'b0;
        unique case (state)
            ST_DRIVE_P: drv_p = !pwr_down;
            ST_DRIVE_N: drv_n = !pwr_down;
            ST_QUIET:   ;
            ST_OFF:     ;
        endcase
    end

    // R7: the two lines are exclusive
    a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(drv_p && drv_n));

    // R7: the two lines never change on the same edge
    a_r7_no_joint_toggle: assert property (@(posedge clk) disable iff (rst)
        ($stable(drv_p) || $stable(drv_n)));

    // R7: the closing clock of every frame is quiet
    a_r7_last_quiet: assert property (@(posedge clk) disable iff (rst)
        wrap |-> (!drv_p && !drv_n));

    // R3: a pulse in progress always has a nonzero stored length
    a_r3_pulse_has_length: assert property (@(posedge clk) disable iff (rst)
        (drv_p || drv_n) |-> (mag_q != '0));
endmodule

// File: tb/sim_pwm3_encoder.sv
module sim_pwm3_encoder;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwr_down = 1'b0;
    logic [5:0] word_in = 6'd0;
    logic       drv_p, drv_n;

    int    n_run = 0;
    int    n_fail = 0;
    string tag = "R1";
    bit    done = 1'b0;

    int m_pos = 0;
    int m_word = 0;
    logic prev_p = 1'b0, prev_n = 1'b0;

    always #2 clk = ~clk;

    pwm3_encoder u0 (
        .clk(clk), .rst(rst), .pwr_down(pwr_down),
        .word_in(word_in), .drv_p(drv_p), .drv_n(drv_n)
    );

    always @(posedge clk) begin
        if (rst || pwr_down) begin
            m_pos = 0;
            m_word = 0;
        end else if (m_pos == 31) begin
            m_pos = 0;
            m_word = $signed(word_in);
        end else begin
            m_pos = m_pos + 1;
        end
    end

    task automatic check_cycle();
        int mag;
        logic ep, en;
        mag = (m_word < 0) ? -m_word : m_word;
        if (mag > 31) mag = 31;
        ep = !pwr_down && (m_word > 0) && (m_pos < mag);
        en = !pwr_down && (m_word < 0) && (m_pos < mag);
        n_run++;
        if (drv_p !== ep || drv_n !== en) begin
            n_fail++;
            $display("FAIL %s: p/n=%b%b expected %b%b (pos %0d word %0d)",
                     tag, drv_p, drv_n, ep, en, m_pos, m_word);
        end
        n_run++;
        if ((drv_p !== prev_p) && (drv_n !== prev_n)) begin
            n_fail++;
            $display("FAIL R7: joint toggle p/n=%b%b expected one stable from %b%b",
                     drv_p, drv_n, prev_p, prev_n);
        end
        prev_p = drv_p;
        prev_n = drv_n;
    endtask

    task automatic step(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            check_cycle();
        end
    endtask

    task automatic frame(input int w, input string t);
        tag = t;
        word_in = 6'(w);
        step(32);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            n_run++;
            if (drv_p !== 1'b0 || drv_n !== 1'b0) begin
                n_fail++;
                $display("FAIL R1: in reset p/n=%b%b expected 00", drv_p, drv_n);
            end
        end
        rst = 1'b0;
        tag = "R1";
        word_in = 6'd5;
        step(31);
        frame(1, "R3");
        frame(2, "R3");
        frame(31, "R3");
        frame(17, "R2");
        frame(-1, "R4");
        frame(-2, "R4");
        frame(-31, "R4");
        frame(0, "R5");
        frame(-32, "R6");
        frame(31, "R7");
        frame(-32, "R7");
        frame(9, "R7");
        tag = "R9";
        for (int f = 0; f < 6; f++) begin
            for (int i = 0; i < 32; i++) begin
                word_in = 6'($urandom);
                step(1);
            end
        end
        frame(20, "R8");
        tag = "R8";
        step(5);
        pwr_down = 1'b1;
        step(40);
        pwr_down = 1'b0;
        word_in = 6'd12;
        step(31);
        frame(-7, "R8");
        frame(3, "R2");
        step(32);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule